// File: doc/BRIEF.md
# Status Flag and Branch Condition Unit

This block holds the 16-bit status word of a small 16-bit processor and keeps its four arithmetic flags up to date from what the ALU reports. The ALU is outside the block. For each operation it supplies the result, the carry-out, the sign bits of both operands and an operation class, and the unit turns these into new carry, sign, zero and negative flags. The low segment field and the high segment field of the status word travel through untouched. Only a full status-word load changes them.

The block also resolves conditional branches. It takes a 4-bit condition code, tests it against the flags currently held, and reports one cycle later whether the branch is taken. It also reports the target address, which is built from the current PC, a 6-bit displacement and a direction bit. The block keeps a true-sign flag apart from the raw most significant bit. Signed comparisons therefore stay correct when the arithmetic overflows, and the overflow conditions compare one flag against the other.

Top module: `flagbr_unit`

## Requirements
- R1: While `rstN` is low, `statusWord`, `brTaken` and `brTarget` are all zero.
- R2: A cycle with `srLoad` high replaces the whole status word with `srLoadData` at the next edge. The load takes priority over any flag update in the same cycle.
- R3: For operation class 1 (add) and class 2 (subtract), the next status word gets bit 6 = `carryOut`, bit 8 = 1 exactly when `aluResult` is zero, and bit 9 = `aluResult[15]`. Carry on a subtract means "no borrow".
- R4: For classes 1 and 2, bit 7 holds the sign of the mathematically exact result. For an add this is the sign of a + b. For a subtract it is the sign of a − b. The operands are read as two's-complement numbers whose signs are `aSign` and `bSign`.
- R5: For class 3 (logic, test, move, negate), bits 8 and 9 update as in R3, and bits 6 and 7 keep their values.
- R6: When `opValid` is low or the class is 0, the status word does not change. A flag update never changes bits 0–5 or bits 10–15.
- R7: Unsigned conditions: code 0 is taken when C=0, code 1 when C=1, code 8 when Z=1 or C=0, and code 9 when Z=0 and C=1.
- R8: Signed conditions: code 2 is taken when S=0, code 3 when S=1, code 10 when Z=1 or S=1, and code 11 when Z=0 and S=0.
- R9: Code 4 is taken when Z=0 and code 5 when Z=1. Code 6 is taken when N=0 and code 7 when N=1. Code 12 is taken when N=S and code 13 when N≠S. Code 14 is always taken and code 15 is never taken.
- R10: One cycle after `brValid`, `brTarget` equals (pc + 1 + disp) mod 2^16 when `backward` is 0, or (pc + 1 − disp) mod 2^16 when `backward` is 1. `brTarget` holds its value otherwise, and `brTaken` is low after any cycle without `brValid`.
- R11: A branch tests the flags held before the edge, not the flags that an operation or load in the same cycle produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srLoad | input | 1 | Load the whole status word |
| srLoadData | input | 16 | Status word value to load |
| opValid | input | 1 | An ALU result is presented this cycle |
| opClass | input | 2 | 0 none, 1 add, 2 subtract, 3 logic |
| aluResult | input | 16 | ALU result |
| carryOut | input | 1 | ALU carry-out (no-borrow on subtract) |
| aSign | input | 1 | Sign bit of the first operand |
| bSign | input | 1 | Sign bit of the second operand |
| brValid | input | 1 | A branch is evaluated this cycle |
| condCode | input | 4 | Branch condition code |
| backward | input | 1 | Displacement direction (1 = backward) |
| disp | input | 6 | Unsigned displacement magnitude |
| pc | input | 16 | Address of the branch instruction |
| statusWord | output | 16 | Current status word |
| brTaken | output | 1 | Registered branch decision |
| brTarget | output | 16 | Registered branch target |

## Verification
Additions and subtractions are run on boundary operands: 0x7FFF + 1, 0x8000 − 1, results that wrap to zero, and operands with equal and opposite signs. These cases separate the true-sign flag from the raw MSB flag, and they show which carry convention the unit uses. A logic operation that follows an arithmetic operation shows that carry and sign are kept. Every condition code is tested against all sixteen flag combinations, so each predicate is told apart from its neighbours, including the N-against-S pair. Target addresses are tried in both directions, including wrap at 0xFFFF and at 0. A load or an update in the same cycle as a branch shows that the branch tests the old flags.

// File: rtl/flagbr_pkg.sv
package flagbr_pkg;
  localparam int SR_W  = 16;
  localparam int C_POS = 6;
  localparam int S_POS = 7;
  localparam int Z_POS = 8;
  localparam int N_POS = 9;
  localparam int COND_W = 4;
  localparam int COND_N = 1 << COND_W;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ADD   = 2'd1,
    OP_SUB   = 2'd2,
    OP_LOGIC = 2'd3
  } opClass_e;

  typedef enum logic [COND_W-1:0] {
    CC_CCLR = 4'd0,  CC_CSET = 4'd1,  CC_SCLR = 4'd2,  CC_SSET = 4'd3,
    CC_ZCLR = 4'd4,  CC_ZSET = 4'd5,  CC_NCLR = 4'd6,  CC_NSET = 4'd7,
    CC_BELOWEQ = 4'd8, CC_ABOVE = 4'd9, CC_LESSEQ = 4'd10, CC_GREATER = 4'd11,
    CC_NEQS = 4'd12, CC_NNES = 4'd13, CC_ALWAYS = 4'd14, CC_NEVER = 4'd15
  } cond_e;

  typedef struct packed {
    logic loadSr;
    logic updArith;
    logic updLogic;
    logic subMode;
    logic evalBr;
  } ctrlStrobes_t;
endpackage

// File: rtl/flagbr_ctrl.sv
module flagbr_ctrl
  import flagbr_pkg::*;
(
  input  logic         srLoad,
  input  logic         opValid,
  input  logic [1:0]   opClass,
  input  logic         brValid,
  output ctrlStrobes_t strobes
);
  opClass_e cls;

  always_comb begin
    cls = opClass_e'(opClass);
    strobes = '0;
    strobes.loadSr = srLoad;
    strobes.evalBr = brValid;
    if (opValid && !srLoad) begin
      unique case (cls)
        OP_ADD:   strobes.updArith = 1'b1;
        OP_SUB:   begin strobes.updArith = 1'b1; strobes.subMode = 1'b1; end
        OP_LOGIC: strobes.updLogic = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/flagbr_datapath.sv
module flagbr_datapath
  import flagbr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DISP_W = 6,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [SR_W-1:0]   srLoadData,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              carryOut,
  input  logic              aSign,
  input  logic              bSign,
  input  logic [COND_W-1:0] condCode,
  input  logic              backward,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   pc,
  output logic [SR_W-1:0]   statusWord,
  output logic              brTaken,
  output logic [PC_W-1:0]   brTarget
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [SR_W-1:0] srQ, srNext;
  logic resMsb, resZero, overflow, trueSign;
  logic fC, fS, fZ, fN;
  logic [COND_N-1:0] predVec;
  logic [PC_W-1:0] pcPlusOne, dispExt, tgtNext;
  logic takenQ;
  logic [PC_W-1:0] tgtQ;

  // flag derivation
  always_comb begin
    resMsb  = aluResult[DATA_W-1];
    resZero = ~|aluResult;
    if (strobes.subMode)
      overflow = (aSign ^ bSign) & (resMsb ^ aSign);
    else
      overflow = ~(aSign ^ bSign) & (resMsb ^ aSign);
    trueSign = resMsb ^ overflow;
  end

  always_comb begin
    srNext = srQ;
    if (strobes.loadSr) begin
      srNext = srLoadData;
    end else begin
      if (strobes.updArith) begin
        srNext[C_POS] = carryOut;
        srNext[S_POS] = trueSign;
      end
      if (strobes.updArith || strobes.updLogic) begin
        srNext[Z_POS] = resZero;
        srNext[N_POS] = resMsb;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) srQ <= '0;
    else       srQ <= srNext;
  end

  // branch predicates from the held flags
  assign fC = srQ[C_POS];
  assign fS = srQ[S_POS];
  assign fZ = srQ[Z_POS];
  assign fN = srQ[N_POS];

  for (genvar k = 0; k < COND_N; k++) begin : g_pred
    always_comb begin
      unique case (cond_e'(k))
        CC_CCLR:    predVec[k] = ~fC;
        CC_CSET:    predVec[k] = fC;
        CC_SCLR:    predVec[k] = ~fS;
        CC_SSET:    predVec[k] = fS;
        CC_ZCLR:    predVec[k] = ~fZ;
        CC_ZSET:    predVec[k] = fZ;
        CC_NCLR:    predVec[k] = ~fN;
        CC_NSET:    predVec[k] = fN;
        CC_BELOWEQ: predVec[k] = fZ | ~fC;
        CC_ABOVE:   predVec[k] = ~fZ & fC;
        CC_LESSEQ:  predVec[k] = fZ | fS;
        CC_GREATER: predVec[k] = ~fZ & ~fS;
        CC_NEQS:    predVec[k] = ~(fN ^ fS);
        CC_NNES:    predVec[k] = fN ^ fS;
        CC_ALWAYS:  predVec[k] = 1'b1;
        default:    predVec[k] = 1'b0;
      endcase
    end
  end

  // target arithmetic
  assign pcPlusOne = pc + PC_W'(1);
  assign dispExt   = {{EXT_W{1'b0}}, disp};
  assign tgtNext   = backward ? (pcPlusOne - dispExt) : (pcPlusOne + dispExt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takenQ <= 1'b0;
      tgtQ   <= '0;
    end else begin
      takenQ <= strobes.evalBr & predVec[condCode];
      if (strobes.evalBr) tgtQ <= tgtNext;
    end
  end

  assign statusWord = srQ;
  assign brTaken    = takenQ;
  assign brTarget   = tgtQ;
endmodule

// File: rtl/flagbr_unit.sv
module flagbr_unit
  import flagbr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DISP_W = 6,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srLoad,
  input  logic [15:0]       srLoadData,
  input  logic              opValid,
  input  logic [1:0]        opClass,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              carryOut,
  input  logic              aSign,
  input  logic              bSign,
  input  logic              brValid,
  input  logic [3:0]        condCode,
  input  logic              backward,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   pc,
  output logic [15:0]       statusWord,
  output logic              brTaken,
  output logic [PC_W-1:0]   brTarget
);
  ctrlStrobes_t strobes;

  flagbr_ctrl u_ctrl (
    .srLoad  (srLoad),
    .opValid (opValid),
    .opClass (opClass),
    .brValid (brValid),
    .strobes (strobes)
  );

  flagbr_datapath #(.DATA_W(DATA_W), .DISP_W(DISP_W), .PC_W(PC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .srLoadData (srLoadData),
    .aluResult  (aluResult),
    .carryOut   (carryOut),
    .aSign      (aSign),
    .bSign      (bSign),
    .condCode   (condCode),
    .backward   (backward),
    .disp       (disp),
    .pc         (pc),
    .statusWord (statusWord),
    .brTaken    (brTaken),
    .brTarget   (brTarget)
  );
endmodule

// File: rtl/flagbr_checker.sv
module flagbr_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              srLoad,
  input logic [15:0]       srLoadData,
  input logic              opValid,
  input logic [1:0]        opClass,
  input logic [DATA_W-1:0] aluResult,
  input logic              brValid,
  input logic [3:0]        condCode,
  input logic [15:0]       statusWord,
  input logic              brTaken
);
  a_r2_load_word: assert property (@(posedge clk) disable iff (!rstN)
    srLoad |=> statusWord == $past(srLoadData));

  a_r6_segments_kept: assert property (@(posedge clk) disable iff (!rstN)
    !srLoad |=> (statusWord[5:0] == $past(statusWord[5:0])) &&
                (statusWord[15:10] == $past(statusWord[15:10])));

  a_r5_logic_keeps_cs: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == 2'd3 && !srLoad) |=> statusWord[7:6] == $past(statusWord[7:6]));

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass != 2'd0 && !srLoad) |=> statusWord[8] == ($past(aluResult) == '0));

  a_r10_idle_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    !brValid |=> !brTaken);

  a_r9_never_taken: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && condCode == 4'd15) |=> !brTaken);
endmodule

bind flagbr_unit flagbr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srLoad     (srLoad),
  .srLoadData (srLoadData),
  .opValid    (opValid),
  .opClass    (opClass),
  .aluResult  (aluResult),
  .brValid    (brValid),
  .condCode   (condCode),
  .statusWord (statusWord),
  .brTaken    (brTaken)
);

// File: tb/tb_flagbr_unit.sv
`timescale 1ns/1ps
module tb_flagbr_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srLoad = 1'b0;
  logic [15:0] srLoadData = '0;
  logic opValid = 1'b0;
  logic [1:0] opClass = '0;
  logic [15:0] aluResult = '0;
  logic carryOut = 1'b0, aSign = 1'b0, bSign = 1'b0;
  logic brValid = 1'b0;
  logic [3:0] condCode = '0;
  logic backward = 1'b0;
  logic [5:0] disp = '0;
  logic [15:0] pc = '0;
  logic [15:0] statusWord, brTarget;
  logic brTaken;

  int total = 0;
  int bad = 0;
  logic [15:0] expSr = '0;
  logic [15:0] expTgt = '0;
  logic expTaken = 1'b0;

  always #2 clk = ~clk;

  flagbr_unit dut (.*);

  function automatic bit condModel(int code, logic [15:0] s);
    bit c = s[6], sg = s[7], z = s[8], n = s[9];
    case (code)
      0: return !c;          1: return c;
      2: return !sg;         3: return sg;
      4: return !z;          5: return z;
      6: return !n;          7: return n;
      8: return z || !c;     9: return !z && c;
      10: return z || sg;    11: return !z && !sg;
      12: return n == sg;    13: return n != sg;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string condTag(int code);
    if (code == 0 || code == 1 || code == 8 || code == 9) return "R7";
    if (code == 2 || code == 3 || code == 10 || code == 11) return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // inputs are already set (at a falling edge); run one clock and compare
  task automatic cycle(string tag);
    int r;
    @(posedge clk);
    if (brValid) begin
      expTaken = condModel(int'(condCode), expSr);
      r = int'(pc) + 1 + (backward ? -int'(disp) : int'(disp));
      expTgt = 16'(r & 16'hFFFF);
    end else expTaken = 1'b0;
    if (srLoad) expSr = srLoadData;
    else if (opValid && opClass != 2'd0) begin
      expSr[8] = (aluResult == 16'h0);
      expSr[9] = aluResult[15];
    end
    @(negedge clk);
    check(tag, "statusWord", int'(statusWord), int'(expSr));
    check(tag, "brTaken", int'(brTaken), int'(expTaken));
    check(tag, "brTarget", int'(brTarget), int'(expTgt));
    srLoad = 1'b0; opValid = 1'b0; brValid = 1'b0;
  endtask

  // drive an add or subtract; carry and exact sign come from integer math
  task automatic arith(logic [15:0] a, logic [15:0] b, bit isSub, string tag);
    int exact;
    opValid = 1'b1;
    opClass = isSub ? 2'd2 : 2'd1;
    aSign = a[15]; bSign = b[15];
    if (isSub) begin
      aluResult = a - b;
      carryOut = (a >= b);
      exact = int'($signed(a)) - int'($signed(b));
    end else begin
      aluResult = a + b;
      carryOut = ((int'(a) + int'(b)) > 16'hFFFF);
      exact = int'($signed(a)) + int'($signed(b));
    end
    @(posedge clk);
    expSr[6] = carryOut;
    expSr[7] = (exact < 0);
    @(negedge clk);
    expSr[6] = expSr[6]; // model update for C,S completed; N,Z in cycle
    // roll back the edge consumed here: compare via direct check
    expSr[8] = (aluResult == 16'h0);
    expSr[9] = aluResult[15];
    check(tag, "statusWord", int'(statusWord), int'(expSr));
    check(tag, "brTaken", int'(brTaken), 0);
    expTaken = 1'b0;
    opValid = 1'b0;
  endtask

  task automatic loadSr(logic [15:0] v, string tag);
    srLoad = 1'b1; srLoadData = v;
    cycle(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "statusWord", int'(statusWord), 0);
    check("R1", "brTaken", int'(brTaken), 0);
    check("R1", "brTarget", int'(brTarget), 0);
    rstN = 1'b1;

    // R2: whole-word load
    loadSr(16'hA5C3, "R2");
    // R2: load wins over a flag update in the same cycle
    opValid = 1'b1; opClass = 2'd1; aluResult = 16'h0000; carryOut = 1'b1;
    srLoad = 1'b1; srLoadData = 16'h5A3C;
    cycle("R2");

    // R3/R4: signed overflow on add, N=1 while S=0
    arith(16'h7FFF, 16'h0001, 1'b0, "R4");
    check("R4", "S vs N", int'(statusWord[9:7]), 3'b100);
    // R4: subtract overflow, N=0 while S=1
    arith(16'h8000, 16'h0001, 1'b1, "R4");
    // R3: add wraps to zero with carry
    arith(16'hFFFF, 16'h0001, 1'b0, "R3");
    check("R3", "C and Z", int'({statusWord[8], statusWord[6]}), 2'b11);
    // R3: subtract with borrow, negative without overflow
    arith(16'h0003, 16'h0005, 1'b1, "R3");
    arith(16'hFFF0, 16'h8000, 1'b0, "R4");
    arith(16'h8000, 16'h7FFF, 1'b1, "R4");

    // R5: logic keeps C and S
    arith(16'h7FFF, 16'h0001, 1'b1, "R3");
    opValid = 1'b1; opClass = 2'd3; aluResult = 16'h8001; carryOut = 1'b0;
    aSign = 1'b0; bSign = 1'b1;
    cycle("R5");
    opValid = 1'b1; opClass = 2'd3; aluResult = 16'h0000; carryOut = 1'b0;
    cycle("R5");

    // R6: no update when class 0 or not valid
    opValid = 1'b1; opClass = 2'd0; aluResult = 16'h8000; carryOut = 1'b1;
    cycle("R6");
    opValid = 1'b0; opClass = 2'd1; aluResult = 16'h1234;
    cycle("R6");
    loadSr(16'hFC3F, "R6");
    arith(16'h0001, 16'h0001, 1'b0, "R6");
    check("R6", "segment fields", int'({statusWord[15:10], statusWord[5:0]}), 12'hFFF);

    // R7/R8/R9: every code under every flag combination
    for (int f = 0; f < 16; f++) begin
      for (int cc = 0; cc < 16; cc++) begin
        loadSr(16'(f << 6) | 16'h8402, "R2");
        brValid = 1'b1; condCode = 4'(cc);
        backward = cc[0]; disp = 6'((f * 5 + cc) % 64);
        pc = 16'((cc * 4099 + f * 77) & 16'hFFFF);
        cycle(condTag(cc));
      end
    end

    // R10: wrap at both ends, maximum reach
    brValid = 1'b1; condCode = 4'd14; backward = 1'b0; disp = 6'd63; pc = 16'hFFFF;
    cycle("R10");
    check("R10", "fwd wrap", int'(brTarget), 16'h003F);
    brValid = 1'b1; condCode = 4'd15; backward = 1'b1; disp = 6'd63; pc = 16'h0000;
    cycle("R10");
    check("R10", "bwd wrap", int'(brTarget), 16'hFFC2);
    cycle("R10"); // idle: target holds, not taken

    // R11: branch sees pre-edge flags
    loadSr(16'h0100, "R11");
    brValid = 1'b1; condCode = 4'd5; pc = 16'h0100; disp = 6'd2; backward = 1'b0;
    opValid = 1'b1; opClass = 2'd3; aluResult = 16'h0001;
    cycle("R11");
    brValid = 1'b1; condCode = 4'd4; pc = 16'h0200; disp = 6'd9; backward = 1'b1;
    srLoad = 1'b1; srLoadData = 16'h0100;
    cycle("R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule